// File: doc/BRIEF.md
# Two-stage PLL frequency calculator

This block works out the output frequency of a cascaded two-stage PLL from three 32-bit words: a reference frequency in kHz, a control word and a coefficient word. The coefficient word carries a multiplier and a divider for each stage. The control word enables the PLL, chooses whether the second stage takes part, and gives a post-divide exponent. Software or a sequencer that must know the present output frequency, for example to compare it with a target before reprogramming, passes the three words in with a one-cycle start pulse. It then waits for a one-cycle done pulse and reads the frequency.

Each stage multiplies into a 64-bit product, so nothing is lost before the divide. It then divides that product on a shared restoring divider that settles one quotient bit per cycle. Each stage keeps the low 32 bits of its quotient. A stage that is enabled but has a zero divider is never launched, and the output is zero instead. After done the result holds until the next accepted start. A start that arrives while a calculation is running has no effect.

Top module: `pll_freq_calc`

## Requirements
- R1: The coefficient word is decoded as M1 = bits 7:0, N1 = bits 15:8, M2 = bits 23:16 and N2 = bits 31:24. The control word is decoded as enable = bit 31, second-stage request = bit 30, second-stage bypass = bit 8 and post-divide exponent P = bits 18:16.
- R2: When the enable bit is clear or M1 is zero, the reported frequency is 0.
- R3: Otherwise the first-stage value is the low 32 bits of floor(ref × N1 / M1). The product is formed at 64 bits, so it is not truncated before the divide.
- R4: The second stage is applied only when bit 30 is set and bit 8 is clear. It replaces the first-stage value with the low 32 bits of floor(stage1 × N2 / M2), again with a 64-bit product.
- R5: When the second stage is applied and M2 is zero, the reported frequency is 0.
- R6: The reported frequency is the last stage value shifted right by P.
- R7: done is high for exactly one cycle per accepted start. busy is high from the cycle after the accepted start until done. The frequency output changes only in the cycle in which done is high, and it holds until the next accepted start.
- R8: A start pulse while busy is high changes neither the result nor the timing of the running calculation.
- R9: After reset, busy and done are low and the frequency output is 0.
- R10: The divider settles one quotient bit per cycle. Count the edge that samples start as edge 1. done is then seen after edge 1 when R2 applies, after edge PROD_W+3 (67) for a single-stage result or for the case in R5, and after edge 2×PROD_W+5 (133) for a two-stage result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request; accepted only while idle |
| ref_khz_i | input | FREQ_W | Reference frequency in kHz |
| ctrl_i | input | 32 | Control word (enable, stage select, bypass, exponent) |
| coef_i | input | 32 | Coefficient word (N2, M2, N1, M1) |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| freq_o | output | FREQ_W | Computed frequency in kHz, held after done |

## Verification
The assertions check several rules on every cycle: done lasts exactly one cycle and never coincides with busy; the output moves only together with done; a zero divider never reaches the divider; and the disabled and zero-M2 cases always report zero. The latched fields stay frozen while busy, whatever happens on start. The actual arithmetic, meaning the truncation of wide products and quotients, the stage-select truth table over bits 30 and 8, and the post-shift, can only be shown by the bench's sweep. The same holds for the exact latency of each path, and for the claim that a start pulse during a run leaves its result and timing untouched.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  localparam int WORD_W        = 32;
  localparam int FIELD_W       = 8;
  localparam int SHIFT_W       = 3;
  localparam int EN_BIT        = 31;
  localparam int S2_REQ_BIT    = 30;
  localparam int S2_BYPASS_BIT = 8;
  localparam int SHIFT_LSB     = 16;
  localparam int NUM_COEF      = WORD_W / FIELD_W;

  typedef struct packed {
    logic               enable;
    logic               use_s2;
    logic [FIELD_W-1:0] n1;
    logic [FIELD_W-1:0] m1;
    logic [FIELD_W-1:0] n2;
    logic [FIELD_W-1:0] m2;
    logic [SHIFT_W-1:0] shift;
  } pll_fields_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STAGE1 = 2'd1,
    ST_STAGE2 = 2'd2
  } calc_state_e;

endpackage

// File: rtl/pll_field_decode.sv
module pll_field_decode
  import pll_calc_pkg::*;
(
  input  logic [WORD_W-1:0] ctrl_i,
  input  logic [WORD_W-1:0] coef_i,
  output pll_fields_t       fields_o
);

  // coefficient bytes, lowest first: M1, N1, M2, N2 (R1)
  logic [FIELD_W-1:0] coef_b [NUM_COEF];

  for (genvar g = 0; g < NUM_COEF; g++) begin : g_coef
    assign coef_b[g] = coef_i[g*FIELD_W +: FIELD_W];
  end

  always_comb begin
    fields_o.m1     = coef_b[0];
    fields_o.n1     = coef_b[1];
    fields_o.m2     = coef_b[2];
    fields_o.n2     = coef_b[3];
    fields_o.enable = ctrl_i[EN_BIT];
    fields_o.use_s2 = ctrl_i[S2_REQ_BIT] & ~ctrl_i[S2_BYPASS_BIT];
    fields_o.shift  = ctrl_i[SHIFT_LSB +: SHIFT_W];
  end

endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 8,
  parameter int QUO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [QUO_W-1:0] quotient_o
);

  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] dvs_q;
  logic [DVS_W-1:0] rem_q;
  logic [QUO_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             valid_q;

  logic [DVS_W:0]   trial_w;
  logic [DVS_W:0]   diff_w;
  logic             take_w;

  always_comb begin
    trial_w = {rem_q, dvd_q[DVD_W-1]};
    take_w  = (trial_w >= {1'b0, dvs_q});
    diff_w  = trial_w - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q   <= '0;
      dvs_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i && !busy_q) begin
        dvd_q  <= dividend_i;
        dvs_q  <= divisor_i;
        rem_q  <= '0;
        quo_q  <= '0;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= take_w ? diff_w[DVS_W-1:0] : trial_w[DVS_W-1:0];
        quo_q <= {quo_q[QUO_W-2:0], take_w};
        dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign valid_o    = valid_q;
  assign quotient_o = quo_q;

  // R10: a zero divisor must never be launched
  a_r10_divisor_nonzero: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |-> (divisor_i != '0));

  // R10: one bit per cycle, the iteration count stays within the dividend width
  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((cnt_q != '0) && (cnt_q <= CNT_W'(DVD_W))));

  // R10: completion is a single-cycle event
  a_r10_valid_once: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int PROD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] ref_khz_i,
  input  logic [WORD_W-1:0] ctrl_i,
  input  logic [WORD_W-1:0] coef_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [FREQ_W-1:0] freq_o
);

  calc_state_e        state_q;
  pll_fields_t        fields_w;
  pll_fields_t        fields_q;
  logic               div_start_q;
  logic [PROD_W-1:0]  dvd_q;
  logic [FIELD_W-1:0] dvs_q;
  logic               div_busy;
  logic               div_valid;
  logic [FREQ_W-1:0]  stage_w;
  logic [FREQ_W-1:0]  freq_q;
  logic               done_q;
  logic               accept_w;

  pll_field_decode u_decode (
    .ctrl_i   (ctrl_i),
    .coef_i   (coef_i),
    .fields_o (fields_w)
  );

  pll_restoring_div #(
    .DVD_W (PROD_W),
    .DVS_W (FIELD_W),
    .QUO_W (FREQ_W)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .start_i    (div_start_q),
    .dividend_i (dvd_q),
    .divisor_i  (dvs_q),
    .busy_o     (div_busy),
    .valid_o    (div_valid),
    .quotient_o (stage_w)
  );

  assign accept_w = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      fields_q    <= '0;
      div_start_q <= 1'b0;
      dvd_q       <= '0;
      dvs_q       <= '0;
      freq_q      <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      div_start_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            fields_q <= fields_w;
            if (!fields_w.enable || (fields_w.m1 == '0)) begin
              freq_q <= '0;
              done_q <= 1'b1;
            end else begin
              dvd_q       <= PROD_W'(ref_khz_i) * PROD_W'(fields_w.n1);
              dvs_q       <= fields_w.m1;
              div_start_q <= 1'b1;
              state_q     <= ST_STAGE1;
            end
          end
        end
        ST_STAGE1: begin
          if (div_valid) begin
            if (!fields_q.use_s2) begin
              freq_q  <= stage_w >> fields_q.shift;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (fields_q.m2 == '0) begin
              freq_q  <= '0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              dvd_q       <= PROD_W'(stage_w) * PROD_W'(fields_q.n2);
              dvs_q       <= fields_q.m2;
              div_start_q <= 1'b1;
              state_q     <= ST_STAGE2;
            end
          end
        end
        ST_STAGE2: begin
          if (div_valid) begin
            freq_q  <= stage_w >> fields_q.shift;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign freq_o = freq_q;

  // R7: done lasts one cycle and is never seen while busy
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7: the output moves only together with done
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (freq_o != $past(freq_o)) |-> done_o);

  // R2: disabled PLL or zero first divider reports zero
  a_r2_disabled_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && (!fields_q.enable || (fields_q.m1 == '0))) |-> (freq_o == '0));

  // R5: selected second stage with zero divider reports zero
  a_r5_m2_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && fields_q.enable && (fields_q.m1 != '0) && fields_q.use_s2 &&
     (fields_q.m2 == '0)) |-> (freq_o == '0));

  // R3: first launch uses M1 as divisor; a zero N1 gives a zero dividend
  a_r3_launch: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STAGE1 && div_start_q) |->
      ((dvs_q == fields_q.m1) && ((fields_q.n1 != '0) || (dvd_q == '0))));

  // R8: a start during a run leaves the latched fields alone
  a_r8_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(fields_q));

  // R10: the shared divider is idle whenever the controller is idle
  a_r10_div_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !div_busy);

endmodule

// File: tb/pll_freq_calc_test.sv
`timescale 1ns/1ps
module pll_freq_calc_test;

  localparam int PROD_W   = 64;
  localparam int LAT_OFF  = 1;
  localparam int LAT_ONE  = PROD_W + 3;
  localparam int LAT_TWO  = 2 * PROD_W + 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ref_khz = '0;
  logic [31:0] ctrl = '0;
  logic [31:0] coef = '0;
  logic        busy;
  logic        done;
  logic [31:0] freq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pll_freq_calc uut (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .ref_khz_i (ref_khz),
    .ctrl_i    (ctrl),
    .coef_i    (coef),
    .busy_o    (busy),
    .done_o    (done),
    .freq_o    (freq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] r, input logic [31:0] c,
                                        input logic [31:0] k, output int lat,
                                        output string tag);
    logic [63:0] s;
    logic [7:0]  n1, m1, n2, m2;
    m1 = k[7:0]; n1 = k[15:8]; m2 = k[23:16]; n2 = k[31:24];
    if (!c[31] || m1 == 0) begin
      lat = LAT_OFF; tag = "R2";
      return 32'd0;
    end
    s = ((64'(r) * 64'(n1)) / 64'(m1)) & 64'hFFFF_FFFF;
    lat = LAT_ONE; tag = "R1 R3 R6";
    if (c[30] && !c[8]) begin
      if (m2 == 0) begin
        tag = "R5";
        return 32'd0;
      end
      s = ((s * 64'(n2)) / 64'(m2)) & 64'hFFFF_FFFF;
      lat = LAT_TWO; tag = "R4 R6";
    end
    return s[31:0] >> c[18:16];
  endfunction

  task automatic run(input logic [31:0] r, input logic [31:0] c, input logic [31:0] k,
                     output logic [31:0] f, output int lat);
    @(negedge clk);
    ref_khz = r; ctrl = c; coef = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    f = freq;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R7 done never reached)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] f, e;
    int lat, elat;
    string tag;
    int idx;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(!busy && !done && freq == 0, "R9 reset state", {busy, done, freq != 0}, 0);

    // sweep: modes over bits 31/30/8, first divider, first multiplier, second divider
    idx = 0;
    for (int mode = 0; mode < 5; mode++) begin
      for (int m1 = 0; m1 < 5; m1++) begin
        for (int ni = 0; ni < 4; ni++) begin
          for (int mi = 0; mi < 3; mi++) begin
            logic [31:0] r, c, k;
            logic [7:0] n1, n2, m2;
            case (idx % 4)
              0: r = 32'd27000;
              1: r = 32'd100000;
              2: r = 32'hFFFF_FFF0;
              default: r = 32'(1 + idx * 13);
            endcase
            case (ni)
              0: n1 = 8'd0;
              1: n1 = 8'd1;
              2: n1 = 8'd7;
              default: n1 = 8'd255;
            endcase
            case (mi)
              0: m2 = 8'd0;
              1: m2 = 8'd1;
              default: m2 = 8'd3;
            endcase
            n2 = 8'(n1 * 3 + 5);
            case (mode)
              0: c = 32'h8000_0000;
              1: c = 32'hC000_0000;
              2: c = 32'hC000_0100;
              3: c = 32'h8000_0100;
              default: c = 32'h4000_0000;
            endcase
            c[18:16] = 3'(idx % 8);
            k = {n2, m2, n1, 8'(m1)};
            e = model(r, c, k, elat, tag);
            run(r, c, k, f, lat);
            check(f == e, {tag, " frequency"}, f, e);
            check(lat == elat, "R10 latency", lat, elat);
            idx++;
          end
        end
      end
    end

    // R7: done is a single pulse and the result holds while idle
    run(32'd48000, 32'hC005_0000, {8'd9, 8'd4, 8'd25, 8'd3}, f, lat);
    e = model(32'd48000, 32'hC005_0000, {8'd9, 8'd4, 8'd25, 8'd3}, elat, tag);
    @(negedge clk);
    check(!done, "R7 done single cycle", done, 0);
    ctrl = 32'h0; coef = 32'h0; ref_khz = 32'h0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(freq == e && !busy, "R7 result held", freq, e);
    end

    // R8: a start during a two-stage run is ignored
    e = model(32'd33333, 32'hC002_0000, {8'd12, 8'd5, 8'd40, 8'd7}, elat, tag);
    @(negedge clk);
    ref_khz = 32'd33333; ctrl = 32'hC002_0000; coef = {8'd12, 8'd5, 8'd40, 8'd7};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      lat++;
    end
    check(busy, "R7 busy during run", busy, 1);
    ref_khz = 32'd5; ctrl = 32'h0; coef = 32'h0101_0101;
    start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    check(freq == e, "R8 result unaffected", freq, e);
    check(lat == LAT_TWO, "R8 timing unaffected", lat, LAT_TWO);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule